// File: doc/BRIEF.md
# Vector Operand Element Broadcast Selector

This block sits on the second-operand path of an eight-lane vector unit whose lanes are 16 bits wide. Each cycle it may accept a 128-bit register value together with a 4-bit element code. It returns a 128-bit operand in which the lanes have been passed through unchanged or replicated, according to the code.

Four replication granularities are encoded in one code. Codes 0 and 1 pass the vector straight through. Codes 2 and 3 replicate one lane within each adjacent pair. Codes 4 to 7 replicate one lane within each group of four. Codes 8 to 15 copy a single lane to all eight outputs.

The result is held in a pipeline register, so it appears one cycle after the input. A valid flag travels with it. The block does no register-file reads, no arithmetic and no memory access.

Top module: `elem_bcast_sel`

## Requirements
- R1: With in_code 0 or 1, out_data equals in_data with every lane in its natural position.
- R2: With in_code 2, both lanes of each adjacent pair (lanes 2k and 2k+1) take the value of input lane 2k. With in_code 3, both take the value of input lane 2k+1.
- R3: With in_code 4 to 7, the vector splits into two groups of four lanes (lanes 0-3 and lanes 4-7). Every output lane of a group takes the input lane at position in_code-4 inside that group.
- R4: With in_code 8 to 15, every output lane takes input lane in_code-8.
- R5: Lane k occupies bits [16k+15:16k]. A lane always moves as a whole, and its high and low bytes are never separated or swapped.
- R6: The selected result appears on out_data one rising edge after it is presented with in_valid high. out_valid equals in_valid delayed by exactly one cycle.
- R7: A synchronous active-high reset clears out_valid and out_data to zero.
- R8: While in_valid is low, out_data keeps its previous value, whatever in_data and in_code carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector and code are valid this cycle |
| in_data | input | 128 | Source register value, lane 0 in bits [15:0] |
| in_code | input | 4 | Element code selecting the replication pattern |
| out_valid | output | 1 | out_data carries a fresh result |
| out_data | output | 128 | Registered operand after lane selection |

## Verification
The bench builds the block with its default parameters: eight lanes of 16 bits and a 4-bit code. At these values all sixteen codes can be exercised against several data patterns. The patterns give each byte of the vector a different value, so a lane taken from the wrong source, or a lane with its bytes swapped, changes the result. Because the lanes are narrow enough to be modelled independently, every code value and the pair, quad and full-broadcast boundaries (codes 2, 3, 4, 7, 8 and 15) can be compared against the bench's own arithmetic lane by lane.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  // Mask of index bits that the code overrides. Zero means identity.
  // The highest set code bit above bit 0 gives the group size 2^b.
  function automatic logic [7:0] ebs_override_mask(input logic [8:0] code, input int code_w);
    logic [7:0] m;
    m = '0;
    for (int k = 1; k < code_w; k++) begin
      if (code[k]) m = 8'((1 << k) - 1);
    end
    return m;
  endfunction

  // Source lane for a given output lane, under the override mask and position.
  function automatic logic [7:0] ebs_source_lane(input logic [7:0] lane,
                                                 input logic [7:0] mask,
                                                 input logic [7:0] pos);
    return (lane & ~mask) | (pos & mask);
  endfunction

endpackage

// File: rtl/ebs_decode.sv
module ebs_decode #(
  parameter int LANES  = 8,
  localparam int IDX_W  = $clog2(LANES),
  localparam int CODE_W = IDX_W + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [IDX_W-1:0]  ovr_mask,
  output logic [IDX_W-1:0]  ovr_pos
);
  import ebs_pkg::*;

  logic [7:0] mask_w;

  always_comb begin
    mask_w   = ebs_override_mask(9'(code), CODE_W);
    ovr_mask = mask_w[IDX_W-1:0];
    ovr_pos  = code[IDX_W-1:0] & ovr_mask;
  end
endmodule

// File: rtl/ebs_lane_mux.sv
module ebs_lane_mux #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0][LANE_W-1:0] src,
  input  logic [IDX_W-1:0]             ovr_mask,
  input  logic [IDX_W-1:0]             ovr_pos,
  output logic [LANES-1:0][LANE_W-1:0] dst
);
  import ebs_pkg::*;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0]       idx_w;
    logic [IDX_W-1:0] idx;
    always_comb begin
      idx_w  = ebs_source_lane(8'(i), 8'(ovr_mask), 8'(ovr_pos));
      idx    = idx_w[IDX_W-1:0];
      dst[i] = src[idx];
    end
  end
endmodule

// File: rtl/ebs_pipe.sv
module ebs_pipe #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d_valid,
  input  logic [WIDTH-1:0] d_data,
  output logic             q_valid,
  output logic [WIDTH-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) q_data <= d_data;
    end
  end
endmodule

// File: rtl/elem_bcast_sel.sv
module elem_bcast_sel #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  localparam int IDX_W  = $clog2(LANES),
  localparam int CODE_W = IDX_W + 1,
  localparam int VEC_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  in_data,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_data
);
  // Named internal events for the checker.
  logic [IDX_W-1:0]             dec_mask;
  logic [IDX_W-1:0]             dec_pos;
  logic                         dec_identity;
  logic [LANES-1:0][LANE_W-1:0] src_lanes;
  logic [LANES-1:0][LANE_W-1:0] sel_lanes;

  assign src_lanes    = in_data;
  assign dec_identity = (dec_mask == '0);

  ebs_decode #(.LANES(LANES)) u_decode (
    .code     (in_code),
    .ovr_mask (dec_mask),
    .ovr_pos  (dec_pos)
  );

  ebs_lane_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_mux (
    .src      (src_lanes),
    .ovr_mask (dec_mask),
    .ovr_pos  (dec_pos),
    .dst      (sel_lanes)
  );

  ebs_pipe #(.WIDTH(VEC_W)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d_data  (VEC_W'(sel_lanes)),
    .q_valid (out_valid),
    .q_data  (out_data)
  );
endmodule

// File: rtl/elem_bcast_sel_chk.sv
module elem_bcast_sel_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  localparam int IDX_W  = $clog2(LANES),
  localparam int CODE_W = IDX_W + 1,
  localparam int VEC_W  = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [VEC_W-1:0]  in_data,
  input logic [CODE_W-1:0] in_code,
  input logic              out_valid,
  input logic [VEC_W-1:0]  out_data,
  input logic              dec_identity
);
  logic [LANES-1:0][LANE_W-1:0] ol;
  assign ol = out_data;

  // R6: valid follows input valid by one cycle
  assert_valid_rise_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R1: identity codes pass data unchanged
  assert_identity_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_identity) |=> (out_data == $past(in_data)));

  // R8: output held while idle
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R4: broadcast codes make all lanes equal lane 0
  for (genvar i = 1; i < LANES; i++) begin : g_bc
    assert_bcast_equal_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_code[CODE_W-1]) |=> (ol[i] == ol[0]));
  end

  // R2: pair codes make both lanes of each pair equal
  for (genvar p = 0; p < LANES/2; p++) begin : g_pair
    assert_pair_equal_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (in_code >> 1) == 1) |=> (ol[2*p] == ol[2*p+1]));
  end

  // R3: quad codes make each group of four lanes uniform
  if (LANES >= 4) begin : g_quad_en
    for (genvar q = 0; q < LANES; q++) begin : g_quad
      assert_quad_equal_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_code >> 2) == 1) |=> (ol[q] == ol[q & ~3]));
    end
  end
endmodule

bind elem_bcast_sel elem_bcast_sel_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_data      (in_data),
  .in_code      (in_code),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .dec_identity (dec_identity)
);

// File: tb/test_elem_bcast_sel.sv
module test_elem_bcast_sel;
  localparam int LANES  = 8;
  localparam int LANE_W = 16;
  localparam int VEC_W  = LANES * LANE_W;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [VEC_W-1:0] in_data;
  logic [3:0]       in_code;
  logic             out_valid;
  logic [VEC_W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [VEC_W-1:0] exp_q[$];
  string            tag_q[$];
  logic [VEC_W-1:0] last_exp = '0;

  always #10 clk = ~clk;  // 50 MHz

  elem_bcast_sel i_elem_bcast_sel (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_code(in_code), .out_valid(out_valid), .out_data(out_data)
  );

  // Bench model written from the requirement text.
  function automatic logic [VEC_W-1:0] model(input logic [VEC_W-1:0] v, input int code);
    logic [VEC_W-1:0] r;
    int s;
    for (int i = 0; i < LANES; i++) begin
      if (code < 2)      s = i;                          // R1
      else if (code < 4) s = i - (i % 2) + (code - 2);   // R2
      else if (code < 8) s = (i / 4) * 4 + (code - 4);   // R3
      else               s = code - 8;                   // R4
      r[i*LANE_W +: LANE_W] = v[s*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input string req, input logic [VEC_W-1:0] v, input int code);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    in_code  = 4'(code);
    exp_q.push_back(model(v, code));
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = {4{32'hDEAD_BEEF}};
      in_code  = 4'(k);
    end
  endtask

  // Monitor: compare each valid result with the front of the scoreboard.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R6 actual=unexpected out_valid expected=no result");
      end else begin
        logic [VEC_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        check(t, out_data, e);
      end
    end
  end

  function automatic logic [VEC_W-1:0] pattern(input int seed);
    logic [VEC_W-1:0] v;
    for (int i = 0; i < LANES; i++)
      v[i*LANE_W +: LANE_W] = {8'(8'h10 * i + seed), 8'(8'h10 * i + seed + 8'h05)};
    return v;
  endfunction

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_code = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    checks++;
    if (out_valid !== 1'b0) begin failures++; $display("FAIL R7 actual=%b expected=0", out_valid); end
    check("R7", out_data, '0);
    rst = 1'b0;

    for (int p = 0; p < 3; p++) begin
      logic [VEC_W-1:0] v;
      v = (p == 2) ? {$urandom, $urandom, $urandom, $urandom} : pattern(p + 1);
      for (int c = 0; c < 16; c++) begin
        if (c < 2)      drive("R1", v, c);
        else if (c < 4) drive("R2", v, c);
        else if (c < 8) drive("R3", v, c);
        else            drive("R4", v, c);
      end
    end
    // R5: whole lanes with distinct bytes, end lanes
    drive("R5", 128'h7766_5544_3322_1100_FFEE_DDCC_BBAA_9988, 8);
    drive("R5", 128'h7766_5544_3322_1100_FFEE_DDCC_BBAA_9988, 15);
    idle(2);
    // R8: output held during idle cycles with changing inputs
    idle(3);
    check("R8", out_data, last_exp);
    // R6: valid low after idle
    checks++;
    if (out_valid !== 1'b0) begin failures++; $display("FAIL R6 actual=%b expected=0", out_valid); end
    // R6: isolated single item, then gap
    drive("R6", pattern(9), 5);
    idle(3);
    // R7: mid-run reset clears the register
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R7", out_data, '0);
    checks++;
    if (out_valid !== 1'b0) begin failures++; $display("FAIL R7 actual=%b expected=0", out_valid); end
    drive("R1", pattern(4), 0);
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin failures++; $display("FAIL R6 actual=%0d pending expected=0", exp_q.size()); end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule